// File: doc/BRIEF.md
# Link Control Symbol CRC-5 Encoder and Receive Queue

This block handles the 24-bit control symbols that manage a serial link. On the transmit side it takes the 19 content bits of a symbol and computes a 5-bit CRC over them. It registers a 32-bit unit whose top byte is a fixed delimiter character, followed by the content and then the CRC.

On the receive side it looks at a 64-bit word each clock. Each 32-bit half of that word may hold one symbol, so zero, one or two symbols can arrive together. Each symbol present has its CRC recomputed and compared. A mismatch is reported straight away on a per-lane error pulse, for the logic that tracks acknowledgements.

All symbols seen in one clock share a single entry of a synchronous FIFO. The entry carries a present flag and a CRC-error flag for each lane. A consumer pops entries with a read strobe. The popped entry is decoded into an acknowledgement class and the raw sub-fields of each symbol. A symbol that is absent or that failed its CRC decodes as "no symbol".

Top module: `csym_link`

## Requirements
- R1: One cycle after `tx_send` is high, `tx_unit_vld` is high and `tx_unit` is {DELIM (8 bits, default 8'h7C), the 19 bits of `tx_content`, the 5-bit CRC of that content}, from MSB to LSB.
- R2: The CRC uses the polynomial x^5+x^4+x^2+1. The register is preset to 5'b11111 and the 19 content bits are shifted in MSB first. For each bit, feedback = crc[4] XOR bit, and crc becomes {crc[3:0],0} XOR (feedback ? 5'b10101 : 0).
- R3: In a cycle that does not follow a `tx_send`, `tx_unit_vld` is low and `tx_unit` is zero.
- R4: Lane 0 is `rx_word[63:32]` and lane 1 is `rx_word[31:0]`. A lane holds a symbol when its top byte equals DELIM. Within a lane the symbol fields are, from MSB: ackclass (3 bits), param0 (5), param1 (5), linkop (3), cmd (3), CRC (5).
- R5: `rx_crc_err[i]` is high in the cycle after lane i held a symbol whose CRC field differs from the CRC of its 19 content bits (R2). The pulse is given even when the FIFO is full.
- R6: A clock in which at least one lane holds a symbol writes exactly one FIFO entry, provided the FIFO is not full. A clock with no symbol writes nothing.
- R7: `fifo_empty` is high when no entry is stored. `fifo_full` is high when DEPTH entries (default 4) are stored. A write arriving while full is dropped. A read and a write in the same clock leave the occupancy unchanged.
- R8: The read-out stage has two states, SHOW_IDLE and SHOW_ENTRY. A read (`rd_en` high while not empty) moves it to SHOW_ENTRY (LOAD from idle, RELOAD from SHOW_ENTRY). A clock without a read moves it to SHOW_IDLE (RETIRE). `dec_vld` is high exactly in SHOW_ENTRY and shows the oldest entry in write order. `rd_en` while empty has no effect.
- R9: For a present, CRC-clean symbol, the class code (3 bits per lane, lane 0 in bits [2:0]) is derived from ackclass as follows: ackclass 0 gives 1 (accepted), 1 gives 2 (retry), 2 gives 3 (not accepted), 4 gives 4 (status), and any other value gives 5 (reserved). `dec_param0`, `dec_param1`, `dec_linkop` and `dec_cmd` carry that lane's fields, with lane 0 in the low bits.
- R10: For a lane that is absent or CRC-failed, the class code is 0 (none) and all of that lane's decoded fields are zero. In SHOW_IDLE all decoded outputs are zero.
- R11: During reset `fifo_empty` is 1, and `fifo_full`, `dec_vld`, `tx_unit_vld` and `rx_crc_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_send | input | 1 | Request to build one control symbol unit |
| tx_content | input | 19 | Symbol content without CRC |
| tx_unit_vld | output | 1 | Built unit is valid |
| tx_unit | output | 32 | Delimiter, content and CRC |
| rx_word | input | 64 | Received word carrying up to two symbol units |
| rx_crc_err | output | 2 | Per-lane CRC error pulse |
| fifo_full | output | 1 | Symbol queue is full |
| fifo_empty | output | 1 | Symbol queue is empty |
| rd_en | input | 1 | Pop one queue entry |
| dec_vld | output | 1 | Decoded entry is presented |
| dec_kind | output | 6 | Class code per lane |
| dec_param0 | output | 10 | param0 per lane |
| dec_param1 | output | 10 | param1 per lane |
| dec_linkop | output | 6 | linkop per lane |
| dec_cmd | output | 6 | cmd per lane |

## Verification
Some properties are checked by the assertions on every cycle. The transmit unit's delimiter and content must match the request of the previous cycle, and the unit must be idle when there was no request. An error pulse may only follow a lane that carried the delimiter. Full and empty never hold together, and full persists while nothing is read. A decoded entry appears only after a real read, and idle decoded outputs stay zero.

Other properties can only be shown by the bench's scenarios. These are the CRC values themselves, that both lanes of a clock land in the same entry, and the first-in-first-out order. They also include the dropping of writes while full, simultaneous read and write, and the exact class mapping with CRC-failed lanes decoding as none.

// File: rtl/csym_pkg.sv
package csym_pkg;
    localparam int CONTENT_W = 19;
    localparam int CRC_W     = 5;
    localparam int SYM_W     = CONTENT_W + CRC_W;
    localparam int UNIT_W    = SYM_W + 8;
    localparam logic [CRC_W-1:0] CRC_POLY   = 5'b10101;
    localparam logic [CRC_W-1:0] CRC_PRESET = 5'b11111;

    typedef enum logic [2:0] {
        K_NONE   = 3'd0,
        K_ACCEPT = 3'd1,
        K_RETRY  = 3'd2,
        K_NOTACC = 3'd3,
        K_STATUS = 3'd4,
        K_RSVD   = 3'd5
    } ack_kind_e;

    // Queue entry: content only, CRC is consumed at the check stage
    typedef struct packed {
        logic [1:0]           bad;
        logic [1:0]           here;
        logic [CONTENT_W-1:0] c1;
        logic [CONTENT_W-1:0] c0;
    } q_entry_t;

    function automatic logic [CRC_W-1:0] crc5(input logic [CONTENT_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic fb;
        r = CRC_PRESET;
        for (int i = CONTENT_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction

    function automatic ack_kind_e class_of(input logic [2:0] ackclass);
        ack_kind_e k;
        unique case (ackclass)
            3'd0:    k = K_ACCEPT;
            3'd1:    k = K_RETRY;
            3'd2:    k = K_NOTACC;
            3'd4:    k = K_STATUS;
            default: k = K_RSVD;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/csym_tx_enc.sv
module csym_tx_enc
    import csym_pkg::*;
#(
    parameter logic [7:0] DELIM = 8'h7C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 send,
    input  logic [CONTENT_W-1:0] content,
    output logic                 unit_vld,
    output logic [UNIT_W-1:0]    unit
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_vld <= 1'b0;
            unit     <= '0;
        end else if (send) begin
            unit_vld <= 1'b1;
            unit     <= {DELIM, content, crc5(content)};
        end else begin
            unit_vld <= 1'b0;
            unit     <= '0;
        end
    end
endmodule

// File: rtl/csym_rx_lane.sv
module csym_rx_lane
    import csym_pkg::*;
#(
    parameter logic [7:0] DELIM = 8'h7C
) (
    input  logic [UNIT_W-1:0]    lane,
    output logic                 present,
    output logic                 crc_bad,
    output logic [CONTENT_W-1:0] content
);
    assign present = (lane[UNIT_W-1 -: 8] == DELIM);
    assign content = lane[SYM_W-1:CRC_W];
    assign crc_bad = present && (crc5(content) != lane[CRC_W-1:0]);
endmodule

// File: rtl/csym_fifo.sv
module csym_fifo
    import csym_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  q_entry_t wdata,
    input  logic     rd,
    output q_entry_t rdata,
    output logic     full,
    output logic     empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    q_entry_t        mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic [CW-1:0]   count;
    logic            do_wr, do_rd;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= bump(wptr);
            if (do_rd) rptr <= bump(rptr);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/csym_decode.sv
module csym_decode
    import csym_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  q_entry_t   entry,
    output logic       vld,
    output logic [5:0] kind,
    output logic [9:0] param0,
    output logic [9:0] param1,
    output logic [5:0] linkop,
    output logic [5:0] cmd
);
    typedef enum logic {SHOW_IDLE, SHOW_ENTRY} show_e;
    show_e state, state_nx;

    always_comb begin
        unique case (state)
            SHOW_IDLE:  state_nx = take ? SHOW_ENTRY : SHOW_IDLE;   // LOAD
            SHOW_ENTRY: state_nx = take ? SHOW_ENTRY : SHOW_IDLE;   // RELOAD / RETIRE
            default:    state_nx = SHOW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SHOW_IDLE;
        else        state <= state_nx;
    end

    assign vld = (state == SHOW_ENTRY);

    // Per-lane decode of the selected entry
    logic [2:0] k_nx [2];
    logic [4:0] p0_nx [2], p1_nx [2];
    logic [2:0] lo_nx [2], cm_nx [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [CONTENT_W-1:0] c;
        logic                 ok;
        assign c  = (g == 0) ? entry.c0 : entry.c1;
        assign ok = entry.here[g] && !entry.bad[g];
        assign k_nx[g]  = ok ? class_of(c[18:16]) : K_NONE;
        assign p0_nx[g] = ok ? c[15:11] : '0;
        assign p1_nx[g] = ok ? c[10:6]  : '0;
        assign lo_nx[g] = ok ? c[5:3]   : '0;
        assign cm_nx[g] = ok ? c[2:0]   : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !take) begin
            kind   <= '0;
            param0 <= '0;
            param1 <= '0;
            linkop <= '0;
            cmd    <= '0;
        end else begin
            kind   <= {k_nx[1], k_nx[0]};
            param0 <= {p0_nx[1], p0_nx[0]};
            param1 <= {p1_nx[1], p1_nx[0]};
            linkop <= {lo_nx[1], lo_nx[0]};
            cmd    <= {cm_nx[1], cm_nx[0]};
        end
    end
endmodule

// File: rtl/csym_link.sv
module csym_link
    import csym_pkg::*;
#(
    parameter int         DEPTH = 4,
    parameter logic [7:0] DELIM = 8'h7C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_send,
    input  logic [18:0] tx_content,
    output logic        tx_unit_vld,
    output logic [31:0] tx_unit,
    input  logic [63:0] rx_word,
    output logic [1:0]  rx_crc_err,
    output logic        fifo_full,
    output logic        fifo_empty,
    input  logic        rd_en,
    output logic        dec_vld,
    output logic [5:0]  dec_kind,
    output logic [9:0]  dec_param0,
    output logic [9:0]  dec_param1,
    output logic [5:0]  dec_linkop,
    output logic [5:0]  dec_cmd
);
    localparam int LANES = 2;

    csym_tx_enc #(.DELIM(DELIM)) u_tx (
        .clk(clk), .rst_n(rst_n), .send(tx_send), .content(tx_content),
        .unit_vld(tx_unit_vld), .unit(tx_unit)
    );

    logic [LANES-1:0]     lane_here, lane_bad;
    logic [CONTENT_W-1:0] lane_c [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_rx
        csym_rx_lane #(.DELIM(DELIM)) u_lane (
            .lane    (rx_word[(LANES-g)*UNIT_W-1 -: UNIT_W]),
            .present (lane_here[g]),
            .crc_bad (lane_bad[g]),
            .content (lane_c[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_crc_err <= '0;
        else        rx_crc_err <= lane_bad;
    end

    q_entry_t wentry, rentry;
    assign wentry.bad  = lane_bad;
    assign wentry.here = lane_here;
    assign wentry.c0   = lane_c[0];
    assign wentry.c1   = lane_c[1];

    csym_fifo #(.DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .wr(|lane_here), .wdata(wentry),
        .rd(rd_en), .rdata(rentry), .full(fifo_full), .empty(fifo_empty)
    );

    csym_decode u_dec (
        .clk(clk), .rst_n(rst_n), .take(rd_en && !fifo_empty), .entry(rentry),
        .vld(dec_vld), .kind(dec_kind), .param0(dec_param0),
        .param1(dec_param1), .linkop(dec_linkop), .cmd(dec_cmd)
    );
endmodule

// File: rtl/csym_link_chk.sv
module csym_link_chk #(
    parameter logic [7:0] DELIM = 8'h7C
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_send,
    input logic [18:0] tx_content,
    input logic        tx_unit_vld,
    input logic [31:0] tx_unit,
    input logic [7:0]  lane0_top,
    input logic [7:0]  lane1_top,
    input logic [1:0]  rx_crc_err,
    input logic        fifo_full,
    input logic        fifo_empty,
    input logic        rd_en,
    input logic        dec_vld,
    input logic [5:0]  dec_kind,
    input logic [9:0]  dec_param0
);
    // R1
    tx_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_unit_vld |-> (tx_unit[31:24] == DELIM && tx_unit[23:5] == $past(tx_content)));
    // R3
    tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_send) |-> (!tx_unit_vld && tx_unit == 32'd0));
    // R5
    err_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_crc_err[0] |-> $past(lane0_top == DELIM));
    // R5
    err_lane1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_crc_err[1] |-> $past(lane1_top == DELIM));
    // R7
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));
    // R7
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !rd_en) |=> fifo_full);
    // R8
    dec_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> $past(rd_en && !fifo_empty));
    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> (dec_kind == 6'd0 && dec_param0 == 10'd0));
endmodule

bind csym_link csym_link_chk #(.DELIM(DELIM)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_send(tx_send), .tx_content(tx_content),
    .tx_unit_vld(tx_unit_vld), .tx_unit(tx_unit),
    .lane0_top(rx_word[63:56]), .lane1_top(rx_word[31:24]),
    .rx_crc_err(rx_crc_err), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .rd_en(rd_en), .dec_vld(dec_vld), .dec_kind(dec_kind), .dec_param0(dec_param0)
);

// File: tb/csym_link_tb.sv
`timescale 1ns/1ps
module csym_link_tb;
    localparam int         DEPTH = 4;
    localparam logic [7:0] DELIM = 8'h7C;
    localparam int         EXP_W = 6 + 10 + 10 + 6 + 6;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        tx_send = 1'b0;
    logic [18:0] tx_content = '0;
    logic        tx_unit_vld;
    logic [31:0] tx_unit;
    logic [63:0] rx_word = '0;
    logic [1:0]  rx_crc_err;
    logic        fifo_full, fifo_empty;
    logic        rd_en = 1'b0;
    logic        dec_vld;
    logic [5:0]  dec_kind, dec_linkop, dec_cmd;
    logic [9:0]  dec_param0, dec_param1;

    always #2 clk = ~clk;

    csym_link #(.DEPTH(DEPTH), .DELIM(DELIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_send(tx_send), .tx_content(tx_content),
        .tx_unit_vld(tx_unit_vld), .tx_unit(tx_unit), .rx_word(rx_word),
        .rx_crc_err(rx_crc_err), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .rd_en(rd_en), .dec_vld(dec_vld), .dec_kind(dec_kind),
        .dec_param0(dec_param0), .dec_param1(dec_param1),
        .dec_linkop(dec_linkop), .dec_cmd(dec_cmd)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [EXP_W-1:0] exp_q [$];
    int   mcount = 0;
    logic [1:0] exp_err = '0;
    bit   exp_show = 1'b0;

    function automatic logic [4:0] ref_crc(input logic [18:0] d);
        logic [4:0] c;
        logic fb;
        c = 5'h1F;
        for (int i = 18; i >= 0; i--) begin
            fb = c[4] ^ d[i];
            c  = {c[3:0], 1'b0} ^ (fb ? 5'b10101 : 5'b00000);
        end
        return c;
    endfunction

    function automatic logic [31:0] mk(input logic [2:0] ac, input logic [4:0] p0,
                                       input logic [4:0] p1, input logic [2:0] lo,
                                       input logic [2:0] cm, input bit corrupt);
        logic [18:0] c;
        c = {ac, p0, p1, lo, cm};
        return {DELIM, c, ref_crc(c) ^ (corrupt ? 5'b00100 : 5'b00000)};
    endfunction

    function automatic logic [EXP_W-1:0] ref_dec(input logic [63:0] w);
        logic [5:0] k; logic [9:0] a, b; logic [5:0] l, m;
        logic [31:0] ln;
        logic [2:0] kc;
        k = '0; a = '0; b = '0; l = '0; m = '0;
        for (int g = 0; g < 2; g++) begin
            ln = (g == 0) ? w[63:32] : w[31:0];
            if (ln[31:24] == DELIM && ref_crc(ln[23:5]) == ln[4:0]) begin
                case (ln[23:21])
                    3'd0: kc = 3'd1;
                    3'd1: kc = 3'd2;
                    3'd2: kc = 3'd3;
                    3'd4: kc = 3'd4;
                    default: kc = 3'd5;
                endcase
                k[g*3 +: 3] = kc;
                a[g*5 +: 5] = ln[20:16];
                b[g*5 +: 5] = ln[15:11];
                l[g*3 +: 3] = ln[10:8];
                m[g*3 +: 3] = ln[7:5];
            end
        end
        return {k, a, b, l, m};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: check outputs of the previous edge, then present one cycle of stimulus
    task automatic cycle(input logic [63:0] w, input bit rd);
        logic [1:0] here, bad;
        bit wr, rdd;
        @(negedge clk);
        chk("R5", "rx_crc_err", 64'(rx_crc_err), 64'(exp_err));
        chk("R7", "fifo_full", 64'(fifo_full), 64'(mcount == DEPTH));
        chk("R6", "fifo_empty", 64'(fifo_empty), 64'(mcount == 0));
        chk("R8", "dec_vld", 64'(dec_vld), 64'(exp_show));
        rx_word = w;
        rd_en   = rd;
        for (int g = 0; g < 2; g++) begin
            logic [31:0] ln;
            ln = (g == 0) ? w[63:32] : w[31:0];
            here[g] = (ln[31:24] == DELIM);
            bad[g]  = here[g] && (ref_crc(ln[23:5]) != ln[4:0]);
        end
        wr  = (|here) && (mcount != DEPTH);
        rdd = rd && (mcount != 0);
        exp_err  = bad;
        exp_show = rdd;
        if (wr) exp_q.push_back(ref_dec(w));
        mcount = mcount + int'(wr) - int'(rdd);
    endtask

    // Monitor: compare each decoded entry against the scoreboard
    always @(negedge clk) begin
        if (rst_n && dec_vld) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R8 unexpected entry: actual %h expected none", dec_kind);
            end else begin
                logic [EXP_W-1:0] e;
                e = exp_q.pop_front();
                chk("R9 R10", "decoded entry",
                    64'({dec_kind, dec_param0, dec_param1, dec_linkop, dec_cmd}), 64'(e));
            end
        end
    end

    task automatic tx_one(input logic [18:0] c);
        @(negedge clk);
        tx_send = 1'b1; tx_content = c;
        @(negedge clk);
        tx_send = 1'b0;
        chk("R1", "tx_unit_vld", 64'(tx_unit_vld), 64'd1);
        chk("R2", "tx_unit", 64'(tx_unit), 64'({DELIM, c, ref_crc(c)}));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "fifo_empty", 64'(fifo_empty), 64'd1);
        chk("R11", "fifo_full", 64'(fifo_full), 64'd0);
        chk("R11", "dec_vld", 64'(dec_vld), 64'd0);
        chk("R11", "tx_unit_vld", 64'(tx_unit_vld), 64'd0);
        chk("R11", "rx_crc_err", 64'(rx_crc_err), 64'd0);
        rst_n = 1'b1;

        tx_one(19'h00000);
        tx_one(19'h7FFFF);
        tx_one(19'h2A5C3);
        @(negedge clk);
        chk("R3", "idle tx_unit_vld", 64'(tx_unit_vld), 64'd0);
        chk("R3", "idle tx_unit", 64'(tx_unit), 64'd0);

        // R4 lanes; R6 one entry per clock; R5 error pulses; R7 fill and drop
        cycle({mk(3'd0, 5'd3, 5'd9, 3'd2, 3'd1, 0), mk(3'd1, 5'd7, 5'd0, 3'd5, 3'd4, 0)}, 0);
        cycle({mk(3'd2, 5'd31, 5'd17, 3'd7, 3'd7, 0), 32'h0}, 0);
        cycle({32'h0, mk(3'd4, 5'd12, 5'd30, 3'd1, 3'd6, 0)}, 0);
        cycle(64'h0, 0);
        cycle({mk(3'd6, 5'd5, 5'd5, 3'd3, 3'd2, 0), mk(3'd0, 5'd1, 5'd2, 3'd3, 3'd4, 1)}, 0);
        cycle({mk(3'd1, 5'd8, 5'd8, 3'd0, 3'd0, 1), mk(3'd2, 5'd9, 5'd9, 3'd1, 3'd1, 1)}, 0);
        cycle(64'h0, 0);
        // Drain, then one read while empty
        for (int i = 0; i < DEPTH + 1; i++) cycle(64'h0, 1);
        // Write with read on empty, then simultaneous read and write
        cycle({mk(3'd4, 5'd21, 5'd10, 3'd6, 3'd5, 1), mk(3'd3, 5'd4, 5'd6, 3'd2, 3'd0, 0)}, 1);
        cycle({32'h0, mk(3'd0, 5'd30, 5'd1, 3'd4, 3'd3, 0)}, 1);
        cycle(64'h0, 1);
        cycle(64'h0, 0);
        cycle(64'h0, 0);
        chk("R8", "scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        finish_run();
    end
endmodule